// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a narrow host bus access to a small bank of byte-wide internal registers through only two host-visible registers. The first is a selection register, which holds the internal address, a strobe-length mode bit and a busy flag. The second is a data register. The internal bank is not on the host bus. The host reaches it only through timed transfers that this bridge runs.

A write to the data register while the bridge is idle latches the byte and starts a write transfer to the selected internal register. A read starts when the host writes the selection register with its busy bit set. At the end of the transfer the selected internal byte is copied into the data register. A transfer lasts a fixed number of system clocks, and the mode bit chooses the short or the long length. Software polls the busy flag before it issues the next request.

The bank holds a 32-bit count value, a 32-bit alarm value and three single-byte control registers. Nothing acts on their contents here. Two reset inputs are provided. The power-on reset initialises everything. The device reset cancels a transfer and clears the bank, but the two host-visible registers keep their contents through it.

Top module: `ind_reg_bridge`

## Requirements
- R1: The selection register reads as: bits 3:0 are the internal address, bit 4 is the short-strobe mode, bits 6:5 read 0, and bit 7 is the busy flag.
- R2: Power-on reset (por_n low) sets the selection register to 0x10, with short mode on, address 0 and not busy. It sets the data register and every internal register to 0x00, and it takes priority over the device reset.
- R3: A host write to the data register (host_sel=1) while idle loads the byte into the data register on that edge and sets busy. The selected internal register takes the byte on the edge where busy clears.
- R4: A host write to the selection register (host_sel=0) with bit 7 set while idle starts a read. On the edge where busy clears, the data register takes the selected internal byte.
- R5: A selection-register write with bit 7 clear while idle changes only the address and the mode bit. Busy stays 0 and the data register is unchanged.
- R6: Busy stays high for exactly 6 clocks if short mode is 1 when the transfer starts, and for exactly 7 clocks if it is 0. The mode value used is the one written in the same request.
- R7: Every host write made while busy is 1 is ignored. This includes the write made on the completing edge. Address, mode, data and the running transfer are not affected.
- R8: Internal addresses: 0x00–0x03 hold the count bytes (low byte first), 0x04 is the control byte, 0x05 the oscillator control byte, 0x06 the oscillator configuration byte, and 0x08–0x0B the alarm bytes. Addresses 0x07 and 0x0C–0x0F read 0x00, and writes to them have no effect.
- R9: The data register keeps its value until the next operation changes it. A started read leaves it unchanged until the read completes.
- R10: Device reset (rst_n low) clears busy, cancels any transfer so that no internal write happens, and clears all internal registers. The address, the mode bit and the data register keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Device reset, active low, synchronous |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | 0 selects the selection register, 1 the data register |
| host_wdata | input | 8 | Host write byte |
| adr_rdata | output | 8 | Current selection register value |
| dat_rdata | output | 8 | Current data register value |

## Verification
The bench writes a distinct byte to every valid address in the short mode and reads all sixteen addresses back. A mismatched value exposes a decode slip, and a nonzero read at 0x07 or 0x0C–0x0F exposes a write that leaked into an undefined slot. The same write/read pair is then repeated in the long mode, which makes a one-cycle error in either busy length visible. Requests issued on the busy cycles, including the last one, separate a guarded request path from one that lets a late write through. A device reset pulse in the middle of a write shows whether the cancelled transfer still lands and whether the host-visible registers survive.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int LONG_CYCLES  = 7,
  parameter int SHORT_CYCLES = 6,
  localparam int NREG  = 16,
  localparam int CNT_W = $clog2(LONG_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] adr_rdata,
  output logic [7:0] dat_rdata
);

  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYCLES - 1);

  function automatic logic slot_valid(input logic [3:0] a);
    return (a <= 4'd6) || (a >= 4'd8 && a <= 4'd11);
  endfunction

  logic [3:0]       addr_q;
  logic             short_q;
  logic [7:0]       dat_q;
  logic             busy_q;
  logic             rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       bank [NREG];

  wire idle     = ~busy_q;
  wire adr_wr   = host_wr & ~host_sel & idle;
  wire start_rd = adr_wr & host_wdata[7];
  wire start_wr = host_wr & host_sel & idle;
  wire done     = busy_q && cnt_q == '0;
  wire len_mode = adr_wr ? host_wdata[4] : short_q;
  wire [7:0] rd_val = slot_valid(addr_q) ? bank[addr_q] : 8'h00;

  assign adr_rdata = {busy_q, 2'b00, short_q, addr_q};
  assign dat_rdata = dat_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      addr_q  <= '0;
      short_q <= 1'b1;
      dat_q   <= '0;
    end else begin
      if (adr_wr) begin
        addr_q  <= host_wdata[3:0];
        short_q <= host_wdata[4];
      end
      if (rst_n) begin
        if (start_wr)
          dat_q <= host_wdata;
        else if (done && rd_q)
          dat_q <= rd_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (start_rd || start_wr) begin
      busy_q <= 1'b1;
      rd_q   <= start_rd;
      cnt_q  <= len_mode ? SHORT_LOAD : LONG_LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (done && !rd_q && slot_valid(addr_q)) begin
      bank[addr_q] <= dat_q;
    end
  end

  logic [CNT_W:0] run_q;
  logic           run_short_q;
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      run_q       <= '0;
      run_short_q <= 1'b0;
    end else if (start_rd || start_wr) begin
      run_q       <= (CNT_W+1)'(1);
      run_short_q <= len_mode;
    end else if (busy_q && !done) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (idle && host_wr && (host_sel || host_wdata[7])) |=> adr_rdata[7]); // R3
  AST_ADR_ONLY_NO_BUSY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (idle && host_wr && !host_sel && !host_wdata[7]) |=> (!adr_rdata[7] && $stable(dat_rdata))); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    done |-> (run_q == (run_short_q ? (CNT_W+1)'(SHORT_CYCLES) : (CNT_W+1)'(LONG_CYCLES)))); // R6
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy_q |=> ($stable(adr_rdata[4:0]))); // R7
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ((busy_q && !(done && rd_q)) || (idle && !(host_wr && host_sel))) |=> $stable(dat_rdata)); // R9
  AST_DAT_WR_CAPTURE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (idle && host_wr && host_sel) |=> (dat_rdata == $past(host_wdata))); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    adr_rdata[6:5] == 2'b00); // R1

endmodule

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b1;
  logic       host_wr = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] adr_rdata, dat_rdata;

  ind_reg_bridge dut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .adr_rdata(adr_rdata), .dat_rdata(dat_rdata));

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit armed = 0, finished = 0;
  string phase = "R2";

  int         m_addr = 0, m_left = 0;
  bit         m_short = 1, m_busy = 0, m_rd = 0;
  logic [7:0] m_dat = 0;
  logic [7:0] m_bank [16];

  function automatic bit defined(int a);
    return (a <= 6) || (a >= 8 && a <= 11);
  endfunction

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic model_step(bit por, bit rst, bit wr, bit sel, logic [7:0] wd);
    if (!por) begin
      m_addr = 0; m_short = 1; m_dat = 0; m_busy = 0; m_left = 0;
      foreach (m_bank[i]) m_bank[i] = 0;
      armed = 1;
    end else if (!rst) begin
      m_busy = 0; m_left = 0;
      foreach (m_bank[i]) m_bank[i] = 0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0;
        if (m_rd) m_dat = defined(m_addr) ? m_bank[m_addr] : 8'h00;
        else if (defined(m_addr)) m_bank[m_addr] = m_dat;
      end
    end else if (wr) begin
      if (sel) begin
        m_dat = wd; m_rd = 0; m_busy = 1;
        m_left = m_short ? 6 : 7;
      end else begin
        m_addr = int'(wd[3:0]); m_short = wd[4];
        if (wd[7]) begin
          m_rd = 1; m_busy = 1;
          m_left = m_short ? 6 : 7;
        end
      end
    end
  endtask

  task automatic cyc(bit por, bit rst, bit wr, bit sel, logic [7:0] wd);
    @(negedge clk);
    if (armed) begin
      check("adr", adr_rdata, {m_busy, 2'b00, m_short, 4'(m_addr)});
      check("dat", dat_rdata, m_dat);
    end
    por_n = por; rst_n = rst; host_wr = wr; host_sel = sel; host_wdata = wd;
    model_step(por, rst, wr, sel, wd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 8'h00);
  endtask

  task automatic wr_reg(int a, logic [7:0] v, bit shrt);
    cyc(1, 1, 1, 0, {3'b000, shrt, 4'(a)});
    cyc(1, 1, 1, 1, v);
    idle(8);
  endtask

  task automatic rd_reg(int a, bit shrt);
    cyc(1, 1, 1, 0, {3'b100, shrt, 4'(a)});
    idle(8);
  endtask

  initial begin
    phase = "R2";
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 0, 0, 0, 8'h00);
    idle(2);
    phase = "R1";
    cyc(1, 1, 1, 0, 8'h6A);
    idle(1);
    phase = "R5";
    cyc(1, 1, 1, 0, 8'h15);
    idle(2);
    phase = "R3";
    cyc(1, 1, 1, 1, 8'hA5);
    idle(8);
    phase = "R4";
    cyc(1, 1, 1, 0, 8'h95);
    idle(8);
    phase = "R8";
    for (int a = 0; a < 16; a++) wr_reg(a, 8'(a * 17 + 3), 1'b1);
    for (int a = 0; a < 16; a++) rd_reg(a, 1'b1);
    phase = "R6";
    wr_reg(9, 8'h3C, 1'b0);
    rd_reg(2, 1'b0);
    rd_reg(9, 1'b0);
    cyc(1, 1, 1, 0, 8'h84);
    idle(8);
    phase = "R7";
    cyc(1, 1, 1, 0, 8'h1A);
    cyc(1, 1, 1, 1, 8'h77);
    cyc(1, 1, 1, 0, 8'h83);
    cyc(1, 1, 1, 1, 8'h5A);
    idle(2);
    cyc(1, 1, 1, 0, 8'h00);
    cyc(1, 1, 1, 1, 8'hEE);
    cyc(1, 1, 1, 1, 8'hDD);
    idle(8);
    rd_reg(10, 1'b1);
    phase = "R9";
    cyc(1, 1, 1, 1, 8'h42);
    idle(8);
    cyc(1, 1, 1, 0, 8'h90);
    idle(3);
    idle(6);
    phase = "R10";
    cyc(1, 1, 1, 0, 8'h14);
    cyc(1, 1, 1, 1, 8'hC3);
    idle(2);
    cyc(1, 0, 0, 0, 8'h00);
    cyc(1, 0, 1, 1, 8'h99);
    idle(8);
    rd_reg(4, 1'b1);
    rd_reg(8, 1'b1);
    phase = "R2";
    cyc(0, 0, 0, 0, 8'h00);
    idle(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule